// File: doc/BRIEF.md
# Burst-of-Two Double-Data-Rate Common-Bus SRAM Model

A synthesizable, cycle-accurate model of a synchronous SRAM that moves data on both clock edges in bursts of two beats. Each rising edge may carry one command, formed by an active-low load strobe, a read/write select and a word address. Every address names a word twice as wide as the data bus. A write delivers its two halves on the rising and falling edges of the cycle after the command, and the assembled word is committed to the array in one operation. A read fetches one double-width word and returns its halves on two consecutive edges, two full cycles after the command.

The shared bidirectional bus is split into a data-in bus, a data-out bus and an output enable. A data-valid flag follows the output enable. Byte-lane write enables (active low) travel with each write beat, not with the command. Written data sits in a pending-write register until the array commit. A read that overlaps that register is served from it lane by lane, so a read issued in the cycle right after a write returns the new data.

`rst_n` is asserted asynchronously and is expected to be released in step with `clk`. The array itself is not reset.

Top module: `burst2_ddr_sram`

## Requirements
- R1: On a rising edge where `ld_n` is high, no command is taken, whatever `rw`, `addr`, `din` and `bw_n` hold. No output cycle follows two cycles later and the array is left unchanged.
- R2: On a rising edge where `ld_n` is low, `rw` high starts a read and `rw` low starts a write.
- R3: A write takes beat 0 from `din` at the first rising edge after the command and beat 1 at the falling edge that follows it. The stored word is {beat 1, beat 0}, with beat 0 in the low `DQ_W` bits.
- R4: `bw_n` is active low and is sampled with each beat. Bit i enables lane i, which is `din[i*9 +: 9]` at the default lane width. A disabled lane keeps its previous array content.
- R5: For a read command sampled at rising edge n:
  - beat 0 (low half) is on `dout` from rising edge n+2 to the next falling edge;
  - beat 1 (high half) is on `dout` from that falling edge to rising edge n+3;
  - `dout_oe` and `qvld` are high for that whole cycle.
- R6: Read commands on consecutive rising edges produce gapless output, one word per cycle, in command order.
- R7: A read issued in any cycle after a write to the same address returns the written data, including the cycle right after the write command. A read issued before the write returns the old data.
- R8: A read issued right after a partial write to the same address returns the new data in the enabled lanes and the old data in the disabled lanes.
- R9: While `rst_n` is low, `dout_oe` and `qvld` are low and `dout` is zero.
- R10: In every cycle that carries no read data, `dout_oe` and `qvld` are low and `dout` is zero.
- R11: Each of the 2**`ADDR_W` addresses holds its own word, with no aliasing between addresses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; both edges carry data |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_n | input | 1 | Active-low command strobe |
| rw | input | 1 | 1 = read, 0 = write |
| addr | input | ADDR_W | Word address |
| din | input | DQ_W | Write data beat |
| bw_n | input | LANES | Active-low lane write enables, one per 9-bit lane |
| dout | output | DQ_W | Read data beat, zero when idle |
| dout_oe | output | 1 | Bus drive enable during read beats |
| qvld | output | 1 | Read data valid |

## Verification
The hardest case to reach is a read whose fetch edge is the same edge at which the pending write commits. Here the array still holds the old word, and the lane masks decide which bytes must come from the pending register. Directed sequences place a full write and a partial write one cycle before a read of the same address. The random phase confines most addresses to four values and mixes in random lane masks, so that write-write-read collisions on one address occur many times. Every read is compared with a bench reference array that is updated at the moment the write command is issued.

// File: rtl/burst2_pkg.sv
package burst2_pkg;
  typedef enum logic [1:0] {
    CMD_NOP = 2'd0,
    CMD_RD  = 2'd1,
    CMD_WR  = 2'd2
  } b2_cmd_e;
endpackage

// File: rtl/b2_wr_gather.sv
// Collects the two write beats (rising then falling edge) into the pending-write register.
module b2_wr_gather #(
  parameter int ADDR_W = 6,
  parameter int LANE_W = 9,
  parameter int LANES  = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_cmd,
  input  logic [ADDR_W-1:0]     cmd_addr,
  input  logic [LANE_W*LANES-1:0] din,
  input  logic [LANES-1:0]      bw_n,
  output logic                  pend_v,
  output logic [ADDR_W-1:0]     pend_addr,
  output logic [2*LANE_W*LANES-1:0] pend_data,
  output logic [2*LANES-1:0]    pend_mask
);
  localparam int DQ_W = LANE_W * LANES;

  logic              wact_q, gact_q, pv_q;
  logic [ADDR_W-1:0] waddr_q, gaddr_q;
  logic [DQ_W-1:0]   lo_d_q;
  logic [LANES-1:0]  lo_m_q;
  logic              wact_d, gact_d, cap_lo, cap_hi;

  always_comb begin
    wact_d = wr_cmd;
    gact_d = wact_q;
    cap_lo = wact_q;
    cap_hi = gact_q;
  end

  // Command stage: address held until the first data beat.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wact_q  <= 1'b0;
      waddr_q <= '0;
    end else begin
      wact_q <= wact_d;
      if (wr_cmd) waddr_q <= cmd_addr;
    end
  end

  // Beat 0 on the rising edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gact_q  <= 1'b0;
      gaddr_q <= '0;
      lo_d_q  <= '0;
      lo_m_q  <= '0;
    end else begin
      gact_q <= gact_d;
      if (cap_lo) begin
        gaddr_q <= waddr_q;
        lo_d_q  <= din;
        lo_m_q  <= ~bw_n;
      end
    end
  end

  // Beat 1 on the falling edge completes the pending word.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pv_q      <= 1'b0;
      pend_addr <= '0;
      pend_data <= '0;
      pend_mask <= '0;
    end else begin
      pv_q <= cap_hi;
      if (cap_hi) begin
        pend_addr <= gaddr_q;
        pend_data <= {din, lo_d_q};
        pend_mask <= {~bw_n, lo_m_q};
      end
    end
  end

  assign pend_v = pv_q;
endmodule

// File: rtl/b2_word_array.sv
// Double-width storage with lane-masked commit and combinational read.
module b2_word_array #(
  parameter int ADDR_W = 6,
  parameter int LANE_W = 9,
  parameter int LANES  = 2
) (
  input  logic                      clk,
  input  logic                      we,
  input  logic [ADDR_W-1:0]         waddr,
  input  logic [2*LANE_W*LANES-1:0] wdata,
  input  logic [2*LANES-1:0]        wmask,
  input  logic [ADDR_W-1:0]         raddr,
  output logic [2*LANE_W*LANES-1:0] rdata
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int WORD_W = 2 * LANE_W * LANES;
  localparam int MASK_W = 2 * LANES;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [WORD_W-1:0] old_word, new_word;

  assign old_word = mem[waddr];

  for (genvar i = 0; i < MASK_W; i++) begin : g_lane
    assign new_word[i*LANE_W +: LANE_W] =
      wmask[i] ? wdata[i*LANE_W +: LANE_W] : old_word[i*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= new_word;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/b2_rd_pipe.sv
// Read path: address stage, fetch with pending-write merge, output stage with edge mux.
module b2_rd_pipe #(
  parameter int ADDR_W = 6,
  parameter int LANE_W = 9,
  parameter int LANES  = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      rd_cmd,
  input  logic [ADDR_W-1:0]         cmd_addr,
  output logic [ADDR_W-1:0]         arr_raddr,
  input  logic [2*LANE_W*LANES-1:0] arr_rdata,
  input  logic                      pend_v,
  input  logic [ADDR_W-1:0]         pend_addr,
  input  logic [2*LANE_W*LANES-1:0] pend_data,
  input  logic [2*LANES-1:0]        pend_mask,
  output logic [LANE_W*LANES-1:0]   dout,
  output logic                      dout_oe
);
  localparam int DQ_W   = LANE_W * LANES;
  localparam int WORD_W = 2 * DQ_W;
  localparam int MASK_W = 2 * LANES;

  logic              rv1_q, rv2_q, oe_q;
  logic [ADDR_W-1:0] ra1_q;
  logic [WORD_W-1:0] rword_q, merged;
  logic [DQ_W-1:0]   olo_q, ohi_q;
  logic              hit;

  assign arr_raddr = ra1_q;
  assign hit       = pend_v && (pend_addr == ra1_q);

  for (genvar i = 0; i < MASK_W; i++) begin : g_merge
    assign merged[i*LANE_W +: LANE_W] = (hit && pend_mask[i]) ?
      pend_data[i*LANE_W +: LANE_W] : arr_rdata[i*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rv1_q   <= 1'b0;
      ra1_q   <= '0;
      rv2_q   <= 1'b0;
      rword_q <= '0;
      oe_q    <= 1'b0;
      olo_q   <= '0;
      ohi_q   <= '0;
    end else begin
      rv1_q <= rd_cmd;
      if (rd_cmd) ra1_q <= cmd_addr;
      rv2_q <= rv1_q;
      if (rv1_q) rword_q <= merged;
      oe_q <= rv2_q;
      if (rv2_q) begin
        olo_q <= rword_q[DQ_W-1:0];
        ohi_q <= rword_q[WORD_W-1:DQ_W];
      end
    end
  end

  // High phase carries beat 0, low phase carries beat 1.
  assign dout    = oe_q ? (clk ? olo_q : ohi_q) : '0;
  assign dout_oe = oe_q;
endmodule

// File: rtl/burst2_ddr_sram.sv
module burst2_ddr_sram
  import burst2_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANE_W = 9,
  parameter int LANES  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ld_n,
  input  logic                    rw,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANE_W*LANES-1:0] din,
  input  logic [LANES-1:0]        bw_n,
  output logic [LANE_W*LANES-1:0] dout,
  output logic                    dout_oe,
  output logic                    qvld
);
  localparam int DQ_W   = LANE_W * LANES;
  localparam int WORD_W = 2 * DQ_W;
  localparam int MASK_W = 2 * LANES;

  b2_cmd_e cmd;
  always_comb begin
    if (ld_n)    cmd = CMD_NOP;
    else if (rw) cmd = CMD_RD;
    else         cmd = CMD_WR;
  end

  logic              pend_v;
  logic [ADDR_W-1:0] pend_addr, arr_raddr;
  logic [WORD_W-1:0] pend_data, arr_rdata;
  logic [MASK_W-1:0] pend_mask;

  b2_wr_gather #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_wr (
    .clk(clk), .rst_n(rst_n), .wr_cmd(cmd == CMD_WR), .cmd_addr(addr),
    .din(din), .bw_n(bw_n), .pend_v(pend_v), .pend_addr(pend_addr),
    .pend_data(pend_data), .pend_mask(pend_mask)
  );

  // Late write: the pending word commits on the rising edge after it completes.
  b2_word_array #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_arr (
    .clk(clk), .we(pend_v), .waddr(pend_addr), .wdata(pend_data),
    .wmask(pend_mask), .raddr(arr_raddr), .rdata(arr_rdata)
  );

  b2_rd_pipe #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_cmd(cmd == CMD_RD), .cmd_addr(addr),
    .arr_raddr(arr_raddr), .arr_rdata(arr_rdata), .pend_v(pend_v),
    .pend_addr(pend_addr), .pend_data(pend_data), .pend_mask(pend_mask),
    .dout(dout), .dout_oe(dout_oe)
  );

  assign qvld = dout_oe;
endmodule

// File: rtl/burst2_sram_chk.sv
module burst2_sram_chk #(
  parameter int ADDR_W = 6,
  parameter int LANE_W = 9,
  parameter int LANES  = 2
) (
  input logic clk,
  input logic rst_n,
  input logic ld_n,
  input logic rw,
  input logic dout_oe
);
  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_n && rw) |=> ##2 dout_oe); // R5
  AST_OE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    dout_oe |-> $past(!ld_n && rw, 3)); // R10
  AST_WRITE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_n && !rw) |=> ##2 !dout_oe); // R2
  AST_STROBE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ld_n |=> ##2 !dout_oe); // R1
endmodule

bind burst2_ddr_sram burst2_sram_chk #(
  .ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)
) u_chk (.*);

// File: tb/tb_burst2_ddr_sram.sv
module tb_burst2_ddr_sram;
  localparam int AW = 6;
  localparam int LW = 9;
  localparam int NL = 2;
  localparam int DQ = LW * NL;
  localparam int WW = 2 * DQ;

  logic          clk, rst_n, ld_n, rw;
  logic [AW-1:0] addr;
  logic [DQ-1:0] din, dout;
  logic [NL-1:0] bw_n;
  logic          dout_oe, qvld;

  burst2_ddr_sram #(.ADDR_W(AW), .LANE_W(LW), .LANES(NL)) dut (
    .clk(clk), .rst_n(rst_n), .ld_n(ld_n), .rw(rw), .addr(addr),
    .din(din), .bw_n(bw_n), .dout(dout), .dout_oe(dout_oe), .qvld(qvld)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int n_chk = 0, n_bad = 0, cyc_n = 0;
  bit done = 1'b0;

  logic [WW-1:0] ref_mem [1 << AW];
  bit            w_v [4];
  logic [DQ-1:0] w_b0 [4], w_b1 [4];
  logic [NL-1:0] w_m0 [4], w_m1 [4];
  bit            e_v [4];
  logic [WW-1:0] e_w [4];
  string         e_tag [4];

  function automatic logic [WW-1:0] apply_wr(logic [WW-1:0] old, logic [DQ-1:0] b0,
      logic [DQ-1:0] b1, logic [NL-1:0] m0n, logic [NL-1:0] m1n);
    logic [WW-1:0] r = old;
    for (int j = 0; j < NL; j++) begin
      if (!m0n[j]) r[j*LW +: LW] = b0[j*LW +: LW];
      if (!m1n[j]) r[DQ + j*LW +: LW] = b1[j*LW +: LW];
    end
    return r;
  endfunction

  task automatic check(bit ok, string tag, string what, logic [WW-1:0] act, logic [WW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [DQ-1:0] rnd_dq();
    logic [31:0] r = $urandom;
    return r[DQ-1:0];
  endfunction

  // One clock cycle: checks the outputs of this cycle, drives the command for the next rising edge.
  task automatic cyc(bit issue, bit rd, logic [AW-1:0] a, logic [DQ-1:0] b0, logic [DQ-1:0] b1,
      logic [NL-1:0] m0n, logic [NL-1:0] m1n, string tag);
    int s  = cyc_n % 4;
    int sp = (cyc_n + 3) % 4;
    int sn = (cyc_n + 1) % 4;
    @(posedge clk); #1;
    if (e_v[s])
      check(dout_oe && qvld && dout == e_w[s][DQ-1:0], e_tag[s], "beat0",
            {{DQ{1'b0}}, dout}, {{DQ{1'b0}}, e_w[s][DQ-1:0]});
    else
      check(!dout_oe && !qvld && dout == '0, "R10", "idle high phase",
            {{DQ{1'b0}}, dout}, '0);
    if (w_v[sp]) begin din = w_b1[sp]; bw_n = w_m1[sp]; end
    else begin din = rnd_dq(); bw_n = NL'($urandom); end
    ld_n = !issue; rw = rd; addr = a;
    w_v[sn] = issue && !rd;
    if (issue && !rd) begin
      w_b0[sn] = b0; w_b1[sn] = b1; w_m0[sn] = m0n; w_m1[sn] = m1n;
      ref_mem[a] = apply_wr(ref_mem[a], b0, b1, m0n, m1n);
    end
    if (issue && rd) begin
      e_v[sp] = 1'b1; e_w[sp] = ref_mem[a]; e_tag[sp] = tag;
    end
    @(negedge clk); #1;
    if (e_v[s])
      check(dout_oe && qvld && dout == e_w[s][WW-1:DQ], e_tag[s], "beat1",
            {{DQ{1'b0}}, dout}, {{DQ{1'b0}}, e_w[s][WW-1:DQ]});
    else
      check(!dout_oe && !qvld && dout == '0, "R10", "idle low phase",
            {{DQ{1'b0}}, dout}, '0);
    e_v[s] = 1'b0;
    if (w_v[s]) begin din = w_b0[s]; bw_n = w_m0[s]; end
    else begin din = rnd_dq(); bw_n = NL'($urandom); end
    cyc_n++;
  endtask

  task automatic wr(logic [AW-1:0] a, logic [DQ-1:0] b0, logic [DQ-1:0] b1,
      logic [NL-1:0] m0n, logic [NL-1:0] m1n);
    cyc(1'b1, 1'b0, a, b0, b1, m0n, m1n, "W");
  endtask
  task automatic rdc(logic [AW-1:0] a, string tag);
    cyc(1'b1, 1'b1, a, '0, '0, '0, '0, tag);
  endtask
  task automatic idle();
    cyc(1'b0, 1'b0, '0, '0, '0, '0, '0, "-");
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 4; i++) begin w_v[i] = 1'b0; e_v[i] = 1'b0; end
    rst_n = 1'b0; ld_n = 1'b1; rw = 1'b0; addr = '0; din = '0; bw_n = '1;
    repeat (3) @(posedge clk);
    #2;
    check(!dout_oe && !qvld && dout == '0, "R9", "reset outputs", {{DQ{1'b0}}, dout}, '0);
    @(negedge clk); #1;
    rst_n = 1'b1;

    // R11: distinct content in every address, then read every address back.
    for (int a = 0; a < (1 << AW); a++)
      wr(AW'(a), DQ'(a * 37 + 5), DQ'(a * 91 + 3), '0, '0);
    for (int a = 0; a < (1 << AW); a++) rdc(AW'(a), "R11");

    // R7: read the cycle right after a write; a read issued just before a write sees old data.
    wr(6'd5, 18'h2AAAA, 18'h15555, '0, '0);
    rdc(6'd5, "R7");
    rdc(6'd6, "R7");
    wr(6'd6, 18'h3FFFF, 18'h00001, '0, '0);
    rdc(6'd6, "R7");
    // R8: partial write followed at once by a read.
    wr(6'd7, 18'h12345, 18'h2BCDE, 2'b01, 2'b10);
    rdc(6'd7, "R8");
    // R3 / R4: write, gap, read back.
    wr(6'd9, 18'h0F0F0, 18'h30303, '0, '0);
    idle(); idle(); idle();
    rdc(6'd9, "R3");
    wr(6'd8, 18'h1FFFF, 18'h2EEEE, 2'b10, 2'b11);
    idle(); idle();
    rdc(6'd8, "R4");
    // R6: back-to-back reads.
    for (int a = 0; a < 8; a++) rdc(AW'(a), "R6");
    // R1: strobe high with a write-looking command must leave address 10 untouched.
    cyc(1'b0, 1'b0, 6'd10, 18'h3FFFF, 18'h3FFFF, '0, '0, "-");
    idle();
    rdc(6'd10, "R1");
    // Write-write-read on one address.
    wr(6'd3, 18'h11111, 18'h22222, '0, '0);
    wr(6'd3, 18'h33333, 18'h04444, 2'b01, 2'b00);
    rdc(6'd3, "R8");

    // Random mix, with collisions on a small address set (R2).
    for (int k = 0; k < 3000; k++) begin
      logic [31:0] r1 = $urandom;
      logic [31:0] r2 = $urandom;
      logic [AW-1:0] a = (r1[3:2] == 2'd0) ? r2[AW-1:0] : AW'(r1[5:4]);
      logic [NL-1:0] m0 = r1[6] ? NL'(r2[9:8]) : '0;
      logic [NL-1:0] m1 = r1[7] ? NL'(r2[11:10]) : '0;
      cyc(r1[1:0] != 2'd0, r1[8], a, rnd_dq(), rnd_dq(), m0, m1, "R2");
    end
    repeat (4) idle();

    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule